// File: doc/BRIEF.md
# Port Access Bitmap Trap Checker

This block decides whether a guest's port input/output access has to be handed to the host. Permission is held in two 4 KiB bitmaps in memory, each with one bit per port. The low bitmap covers ports 0x0000 to 0x7FFF and the high bitmap covers ports 0x8000 to 0xFFFF. A set bit means that an access touching that port must trap.

A request gives a port number, an access size of 1, 2 or 4 bytes, an enable control and the base addresses of both bitmaps. The request is presented with a one-cycle `start` pulse. The access touches ports `port_num` through `port_num + acc_size - 1`. The block reads the one or two bitmap bytes that hold those bits through a byte-wide read port. It then reports the verdict with a one-cycle `done` pulse, together with a `trap` flag and an `align_err` flag. Sizes other than 1, 2 and 4 are not supported.

When the control is off, or when the request can be settled without memory, the answer comes in one cycle and no read is issued. When two bytes are needed and the first one already shows a set bit, the second read is skipped.

Top module: `pat_trap_checker`

## Requirements
- R1: With `bmp_en` = 0, a start yields `done` = 1 in the next cycle with `trap` = 0 and `align_err` = 0, and `rd_req` stays 0.
- R2: With `bmp_en` = 1 and bits [11:0] of either base address nonzero, a start yields `done` = 1 in the next cycle with `align_err` = 1 and `trap` = 0, and no read is issued.
- R3: With `bmp_en` = 1, both bases aligned and `port_num + acc_size - 1` above 0xFFFF, a start yields `done` = 1 in the next cycle with `trap` = 1, and no read is issued.
- R4: The bitmap byte for port p is read at `base_lo + p[14:3]` when p[15] = 0 and at `base_hi + p[14:3]` when p[15] = 1. The bit for port p is bit p[2:0] of that byte, where bit 0 is the least significant bit.
- R5: For an enabled, aligned access that does not overflow, `trap` equals the OR of the bitmap bits of every port the access touches.
- R6: When the span crosses a byte boundary, a second read fetches the byte that holds the last port. A span from 0x7FFF into 0x8000 reads the first byte from the low bitmap and the second from the high bitmap.
- R7: When the first byte holds a set bit for a port in the span, no second read is issued and `trap` = 1.
- R8: `rd_req` stays high with `rd_addr` unchanged until `rd_valid` is seen. `done` rises in the cycle after the last accepted `rd_valid` and lasts one cycle. `trap` and `align_err` are 0 whenever `done` is 0. After reset `done`, `rd_req`, `trap` and `align_err` are 0.
- R9: A start that arrives while reads are in progress is ignored. The running request finishes with its own addresses and verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request strobe, accepted only while idle |
| port_num | input | 16 | First port touched by the access |
| acc_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| bmp_en | input | 1 | Consult the bitmaps when 1 |
| base_lo | input | 64 | Physical base of the bitmap for ports 0x0000-0x7FFF |
| base_hi | input | 64 | Physical base of the bitmap for ports 0x8000-0xFFFF |
| rd_addr | output | 64 | Byte address of the bitmap read |
| rd_req | output | 1 | Read request, held until `rd_valid` |
| rd_data | input | 8 | Read data byte |
| rd_valid | input | 1 | Read data valid for one cycle |
| done | output | 1 | One-cycle verdict strobe |
| trap | output | 1 | Access must trap; valid with `done` |
| align_err | output | 1 | A base address is not 4 KiB aligned; valid with `done` |

## Verification
The embedded assertions check the following on every cycle:
- the one-cycle answers for a disabled control, a misaligned base and a span that runs past 0xFFFF;
- that the request address holds steady until data returns;
- that a hit in the returned byte leads straight to a trapping `done`;
- that the verdict flags never appear without `done`.

Some behaviour only the bench scenarios can show. These are the exact byte addresses chosen for each span, the split of a 0x7FFF/0x8000 span across both bitmaps, the correctness of the final verdict against the bitmap contents, the skipped second read, and the fact that a start during a busy period leaves the running request untouched. In these scenarios the memory latency varies from request to request.

// File: rtl/pat_pkg.sv
// Package pat_pkg
// Shared state encoding and sizing constants for the port access trap checker.
// Assumes bitmaps of one bit per port, packed eight ports to a byte.
package pat_pkg;

    localparam int BYTE_BITS = 8;
    localparam int BIT_IDX_W = 3;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } pat_state_e;

endpackage

// File: rtl/pat_align_check.sv
// Module pat_align_check
// Flags either bitmap base whose low PAGE_BITS bits are not all zero.
// Purely combinational; the controller samples the flag with start.
module pat_align_check #(
    parameter int ADDR_W    = 64,
    parameter int PAGE_BITS = 12
) (
    input  logic [ADDR_W-1:0] base_lo,
    input  logic [ADDR_W-1:0] base_hi,
    output logic              misalign
);

    // Any nonzero offset inside the page breaks alignment
    always_comb begin
        misalign = (|base_lo[PAGE_BITS-1:0]) | (|base_hi[PAGE_BITS-1:0]);
    end

endmodule

// File: rtl/pat_span_decode.sv
// Module pat_span_decode
// Turns a port number and access size into at most two bitmap byte
// addresses with per-byte bit masks, plus a flag for a span past the top
// port. Assumes acc_size is 1, 2 or 4 so the span touches at most two bytes.
module pat_span_decode
    import pat_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 3
) (
    input  logic [PORT_W-1:0] port_num,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic [ADDR_W-1:0] base_lo,
    input  logic [ADDR_W-1:0] base_hi,
    output logic              overflow,
    output logic              need2,
    output logic [ADDR_W-1:0] addr0,
    output logic [ADDR_W-1:0] addr1,
    output logic [BYTE_BITS-1:0] mask0,
    output logic [BYTE_BITS-1:0] mask1
);

    localparam int SPAN_W = BIT_IDX_W + 1;
    localparam int IDX_W  = PORT_W - 1 - BIT_IDX_W;
    localparam int LANES  = 2;

    logic [PORT_W:0]   end_ext;
    logic [PORT_W-1:0] end_port;
    logic [SPAN_W-1:0] lo_bit;
    logic [SPAN_W-1:0] hi_bit;
    logic [PORT_W-1:0] lane_port [LANES];
    logic [ADDR_W-1:0] lane_addr [LANES];

    // Last port of the span, one bit wider to expose a wrap past the top
    always_comb begin
        end_ext  = {1'b0, port_num} + (PORT_W+1)'(acc_size) - (PORT_W+1)'(1);
        end_port = end_ext[PORT_W-1:0];
        overflow = end_ext[PORT_W];
    end

    // Bit positions of the span measured from the first byte's bit 0
    always_comb begin
        lo_bit = {1'b0, port_num[BIT_IDX_W-1:0]};
        hi_bit = lo_bit + SPAN_W'(acc_size) - SPAN_W'(1);
        need2  = hi_bit[BIT_IDX_W];
    end

    // Masks of touched bits in the first and the second byte
    always_comb begin
        for (int b = 0; b < BYTE_BITS; b++) begin
            mask0[b] = (SPAN_W'(b) >= lo_bit) && (SPAN_W'(b) <= hi_bit);
            mask1[b] = (SPAN_W'(b + BYTE_BITS) <= hi_bit);
        end
    end

    assign lane_port[0] = port_num;
    assign lane_port[1] = end_port;

    // One address lane per byte: the top port bit picks the bitmap
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_addr[g] = (lane_port[g][PORT_W-1] ? base_hi : base_lo)
                            + ADDR_W'(lane_port[g][PORT_W-2 -: IDX_W]);
    end

    assign addr0 = lane_addr[0];
    assign addr1 = lane_addr[1];

endmodule

// File: rtl/pat_fetch_ctrl.sv
// Module pat_fetch_ctrl
// Accepts a start while idle, settles the request at once when no read is
// needed, otherwise reads one or two bitmap bytes and stops at the first hit.
// Assumes rd_valid returns once per held request and lasts one cycle.
module pat_fetch_ctrl
    import pat_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 bmp_en,
    input  logic                 misalign,
    input  logic                 overflow,
    input  logic                 need2,
    input  logic [ADDR_W-1:0]    addr0,
    input  logic [ADDR_W-1:0]    addr1,
    input  logic [BYTE_BITS-1:0] mask0,
    input  logic [BYTE_BITS-1:0] mask1,
    input  logic [BYTE_BITS-1:0] rd_data,
    input  logic                 rd_valid,
    output logic [ADDR_W-1:0]    rd_addr,
    output logic                 rd_req,
    output logic                 done,
    output logic                 trap,
    output logic                 align_err
);

    pat_state_e          state_q;
    logic                phase_q;
    logic                need2_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [ADDR_W-1:0]   addr1_q;
    logic [BYTE_BITS-1:0] mask0_q;
    logic [BYTE_BITS-1:0] mask1_q;
    logic                done_q;
    logic                trap_q;
    logic                err_q;
    logic [BYTE_BITS-1:0] cur_mask;
    logic                hit;
    logic                idle;

    // Mask of the byte now being read and whether it holds a set bit
    always_comb begin
        cur_mask = phase_q ? mask1_q : mask0_q;
        hit      = |(rd_data & cur_mask);
        idle     = (state_q == ST_IDLE);
    end

    // Request sequencing and verdict registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= 1'b0;
            need2_q <= 1'b0;
            addr_q  <= '0;
            addr1_q <= '0;
            mask0_q <= '0;
            mask1_q <= '0;
            done_q  <= 1'b0;
            trap_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            trap_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (!bmp_en) begin
                            done_q <= 1'b1;
                        end else if (misalign) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end else if (overflow) begin
                            done_q <= 1'b1;
                            trap_q <= 1'b1;
                        end else begin
                            state_q <= ST_FETCH;
                            phase_q <= 1'b0;
                            need2_q <= need2;
                            addr_q  <= addr0;
                            addr1_q <= addr1;
                            mask0_q <= mask0;
                            mask1_q <= mask1;
                        end
                    end
                end
                ST_FETCH: begin
                    if (rd_valid) begin
                        if (hit) begin
                            done_q  <= 1'b1;
                            trap_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (!phase_q && need2_q) begin
                            phase_q <= 1'b1;
                            addr_q  <= addr1_q;
                        end else begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_req    = (state_q == ST_FETCH);
    assign rd_addr   = addr_q;
    assign done      = done_q;
    assign trap      = trap_q;
    assign align_err = err_q;

    // R1: disabled control answers next cycle without trapping
    a_r1_disabled_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle && !bmp_en) |=> (done && !trap && !align_err));

    // R1: disabled control issues no read
    a_r1_disabled_noread: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle && !bmp_en) |=> !rd_req);

    // R2: misaligned base reports the error flag next cycle
    a_r2_misalign_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle && bmp_en && misalign) |=> (done && align_err && !trap && !rd_req));

    // R3: span past the top port traps next cycle without reading
    a_r3_overflow_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle && bmp_en && !misalign && overflow) |=> (done && trap && !rd_req));

    // R7: a set bit in the returned byte ends the request with a trap
    a_r7_hit_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid && hit) |=> (done && trap && !rd_req));

    // R8: pending request keeps its address and produces no verdict
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr) && !done));

    // R8: flags only accompany done
    a_r8_trap_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> done);

    // R8: error flag only accompanies done
    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> done);

endmodule

// File: rtl/pat_trap_checker.sv
// Module pat_trap_checker
// Top of the port access trap checker: alignment screen, span decoder and
// read controller. Assumes acc_size is 1, 2 or 4 and that the memory answers
// each held read with a one-cycle rd_valid.
module pat_trap_checker
    import pat_pkg::*;
#(
    parameter int PORT_W    = 16,
    parameter int ADDR_W    = 64,
    parameter int SIZE_W    = 3,
    parameter int PAGE_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [PORT_W-1:0]    port_num,
    input  logic [SIZE_W-1:0]    acc_size,
    input  logic                 bmp_en,
    input  logic [ADDR_W-1:0]    base_lo,
    input  logic [ADDR_W-1:0]    base_hi,
    output logic [ADDR_W-1:0]    rd_addr,
    output logic                 rd_req,
    input  logic [BYTE_BITS-1:0] rd_data,
    input  logic                 rd_valid,
    output logic                 done,
    output logic                 trap,
    output logic                 align_err
);

    logic                 misalign;
    logic                 overflow;
    logic                 need2;
    logic [ADDR_W-1:0]    addr0;
    logic [ADDR_W-1:0]    addr1;
    logic [BYTE_BITS-1:0] mask0;
    logic [BYTE_BITS-1:0] mask1;

    pat_align_check #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_align (
        .base_lo  (base_lo),
        .base_hi  (base_hi),
        .misalign (misalign)
    );

    pat_span_decode #(
        .PORT_W (PORT_W),
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W)
    ) u_span (
        .port_num (port_num),
        .acc_size (acc_size),
        .base_lo  (base_lo),
        .base_hi  (base_hi),
        .overflow (overflow),
        .need2    (need2),
        .addr0    (addr0),
        .addr1    (addr1),
        .mask0    (mask0),
        .mask1    (mask1)
    );

    pat_fetch_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .bmp_en    (bmp_en),
        .misalign  (misalign),
        .overflow  (overflow),
        .need2     (need2),
        .addr0     (addr0),
        .addr1     (addr1),
        .mask0     (mask0),
        .mask1     (mask1),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rd_addr   (rd_addr),
        .rd_req    (rd_req),
        .done      (done),
        .trap      (trap),
        .align_err (align_err)
    );

    // R9: a fresh start during a read does not end the pending request early
    a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid && start) |=> (rd_req && !done));

endmodule

// File: tb/sim_pat_trap_checker.sv
`timescale 1ns/1ps
module sim_pat_trap_checker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] port_num = '0;
    logic [2:0]  acc_size = 3'd1;
    logic        bmp_en = 1'b0;
    logic [63:0] base_lo = '0;
    logic [63:0] base_hi = '0;
    logic [63:0] rd_addr;
    logic        rd_req;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        done;
    logic        trap;
    logic        align_err;

    int vectors = 0;
    int miscompares = 0;
    int lat = 0;
    int lat_cnt = 0;
    logic [63:0] cur_lo = 64'h0000_0001_0000_0000;
    logic [63:0] cur_hi = 64'h0000_0002_0000_3000;

    always #4 clk = ~clk;

    pat_trap_checker u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .port_num(port_num),
        .acc_size(acc_size), .bmp_en(bmp_en), .base_lo(base_lo), .base_hi(base_hi),
        .rd_addr(rd_addr), .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid),
        .done(done), .trap(trap), .align_err(align_err)
    );

    // Bitmap content as a function of the port: roughly one port in eight set
    function automatic bit gbit(int unsigned p);
        int unsigned h;
        h = p * 32'h9E37_79B1;
        return (h[20:18] == 3'd0);
    endfunction

    // Byte seen by the memory model at a byte address
    function automatic logic [7:0] mem_byte(logic [63:0] a);
        logic [63:0] off;
        int unsigned bp;
        logic [7:0] v;
        off = a - cur_lo;
        if (off < 64'd4096) bp = int'(off) * 8;
        else begin
            off = a - cur_hi;
            if (off < 64'd4096) bp = 32768 + int'(off) * 8;
            else return 8'hFF;
        end
        for (int b = 0; b < 8; b++) v[b] = gbit(bp + b);
        return v;
    endfunction

    // Memory model: answers a held request after lat+1 cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            lat_cnt  <= 0;
        end else begin
            rd_valid <= 1'b0;
            if (rd_req && !rd_valid) begin
                if (lat_cnt >= lat) begin
                    rd_valid <= 1'b1;
                    rd_data  <= mem_byte(rd_addr);
                    lat_cnt  <= 0;
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One request against a behavioural reference, compared on every clock
    task automatic run(input logic [15:0] p, input int sz, input bit en,
                       input logic [63:0] blo, input logic [63:0] bhi,
                       input bit poke, input string req);
        logic [63:0] addrs[$];
        int nf;
        bit etrap;
        bit eerr;
        int idx;
        bit fin;
        nf = 0; etrap = 0; eerr = 0; idx = 0; fin = 0;
        cur_lo = blo;
        cur_hi = bhi;
        if (!en) begin
            nf = 0;
        end else if (blo[11:0] != 0 || bhi[11:0] != 0) begin
            eerr = 1;
        end else if (int'(p) + sz - 1 > 65535) begin
            etrap = 1;
        end else begin
            int bytes[$];
            for (int q = int'(p); q < int'(p) + sz; q++)
                if (bytes.size() == 0 || bytes[bytes.size()-1] != (q >> 3)) bytes.push_back(q >> 3);
            foreach (bytes[k]) begin
                bit hitb;
                hitb = 0;
                addrs.push_back(((bytes[k] >= 4096) ? bhi : blo) + 64'(bytes[k] % 4096));
                nf++;
                for (int q = int'(p); q < int'(p) + sz; q++)
                    if ((q >> 3) == bytes[k] && gbit(q)) hitb = 1;
                if (hitb) begin
                    etrap = 1;
                    break;
                end
            end
        end
        @(negedge clk);
        port_num = p; acc_size = 3'(sz); bmp_en = en; base_lo = blo; base_hi = bhi;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 64; cyc++) begin
            if (idx == nf) begin
                start = 1'b0;
                chk(req, "done", 64'(done), 64'd1);
                chk(req, "trap", 64'(trap), 64'(etrap));
                chk(req, "align_err", 64'(align_err), 64'(eerr));
                chk(req, "rd_req at done", 64'(rd_req), 64'd0);
                fin = 1;
                break;
            end
            chk(req, "done while reading", 64'(done), 64'd0);
            chk(req, "rd_req", 64'(rd_req), 64'd1);
            chk(req, "rd_addr", rd_addr, addrs[idx]);
            if (poke) begin
                port_num = ~p; acc_size = 3'd1; bmp_en = 1'b0;
                start = 1'b1;
            end
            if (rd_valid) idx++;
            @(negedge clk);
        end
        if (!fin) chk(req, "completion", 64'd0, 64'd1);
        @(negedge clk);
        chk("R8", "done pulse width", 64'(done), 64'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(8 * 150000);
        miscompares++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [63:0] lo_ok;
        logic [63:0] hi_ok;
        int sizes[3];
        lo_ok = 64'h0000_0001_0000_0000;
        hi_ok = 64'h0000_0002_0000_3000;
        sizes = '{1, 2, 4};
        repeat (4) @(negedge clk);
        chk("R8", "reset done", 64'(done), 64'd0);
        chk("R8", "reset rd_req", 64'(rd_req), 64'd0);
        chk("R8", "reset trap", 64'(trap), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: control off, any port
        run(16'h0123, 4, 1'b0, lo_ok, hi_ok, 1'b0, "R1");
        run(16'hFFFF, 4, 1'b0, 64'h5, hi_ok, 1'b0, "R1");
        // R2: misaligned low or high base
        run(16'h0040, 1, 1'b1, lo_ok + 64'h10, hi_ok, 1'b0, "R2");
        run(16'h9000, 2, 1'b1, lo_ok, hi_ok + 64'h800, 1'b0, "R2");
        // R3: span past the top port
        run(16'hFFFE, 4, 1'b1, lo_ok, hi_ok, 1'b0, "R3");
        run(16'hFFFF, 2, 1'b1, lo_ok, hi_ok, 1'b0, "R3");
        // R4: single ports at the ends of each bitmap
        lat = 0;
        run(16'hFFFF, 1, 1'b1, lo_ok, hi_ok, 1'b0, "R4");
        run(16'h0000, 1, 1'b1, lo_ok, hi_ok, 1'b0, "R4");
        run(16'h8000, 1, 1'b1, lo_ok, hi_ok, 1'b0, "R4");
        run(16'h7FFF, 1, 1'b1, lo_ok, hi_ok, 1'b0, "R4");
        // R6: span across the bitmap split and across bytes
        lat = 2;
        run(16'h7FFF, 2, 1'b1, lo_ok, hi_ok, 1'b0, "R6");
        run(16'h7FFE, 4, 1'b1, lo_ok, hi_ok, 1'b0, "R6");
        // R7 / R6: early stop versus second read on a two-byte span
        begin
            bit got_hit;
            bit got_miss;
            got_hit = 0;
            got_miss = 0;
            for (int q = 6; q < 65000 && !(got_hit && got_miss); q += 8) begin
                if (!got_hit && (gbit(q) || gbit(q + 1))) begin
                    run(16'(q), 4, 1'b1, lo_ok, hi_ok, 1'b0, "R7");
                    got_hit = 1;
                end else if (!got_miss && !gbit(q) && !gbit(q + 1) && (gbit(q + 2) || gbit(q + 3))) begin
                    run(16'(q), 4, 1'b1, lo_ok, hi_ok, 1'b0, "R6");
                    got_miss = 1;
                end
            end
        end
        // R9: starts during reads are ignored
        lat = 1;
        run(16'h1236, 4, 1'b1, lo_ok, hi_ok, 1'b1, "R9");
        run(16'hC00F, 2, 1'b1, lo_ok, hi_ok, 1'b1, "R9");
        // R5: random accesses with varied latency
        for (int t = 0; t < 400; t++) begin
            logic [15:0] p;
            int sz;
            bit en;
            p = 16'($urandom);
            if (t % 5 == 0) p = 16'h7FF8 + 16'($urandom_range(0, 15));
            sz = sizes[$urandom_range(0, 2)];
            en = ($urandom_range(0, 9) != 0);
            lat = $urandom_range(0, 2);
            lo_ok = {40'h1, 12'($urandom), 12'h000};
            hi_ok = {40'h2, 12'($urandom), 12'h000};
            run(p, sz, en, lo_ok, hi_ok, (t % 7 == 3), "R5");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule